// File: doc/BRIEF.md
# UART Receiver with Two-Entry Status FIFO

This block is the receive half of a serial port. It watches an asynchronous RX line, finds start bits with a 16x oversampling tick, and assembles 8-data-bit, no-parity, one-stop-bit characters. Each finished character enters a small first-in first-out store together with two status bits: a framing error and an overrun marker. A host reads one character per read strobe. Each read removes the character at the head. The data and status of the head are visible on the outputs before the strobe arrives.

If both FIFO slots are occupied, one more finished character can wait in a holding register. It moves into the FIFO in the same cycle as the read that frees a slot. If a new start bit is confirmed while the FIFO is full and a character is still waiting, that waiting character is discarded. The newest character in the FIFO is then tagged with an overrun. Clearing the receiver enable empties the FIFO and the holding register and returns the bit sampler to idle. A "data available" output follows FIFO occupancy. An interrupt request is that signal gated by an enable input.

Top module: `uart_rx_buffer`

## Requirements
- R1: After a synchronous reset, `rx_avail` and `irq` are 0.
- R2: A start is accepted only if the synchronised line is still low on the 8th oversample tick after the falling edge. Each of the 8 data bits (least significant first) and the stop bit is then sampled at the centre of its bit, 16 ticks apart. A low pulse shorter than half a bit produces no character.
- R3: The FIFO holds up to two characters and returns them in arrival order. `rd_data`, `rd_ferr` and `rd_ovr` always show the head entry, and a cycle with `rd_stb` high removes it.
- R4: `rx_avail` is 1 exactly when the FIFO holds at least one unread character.
- R5: `rd_stb` while the FIFO is empty has no effect: a later character is read back normally, and `rx_avail` returns to 0 after that single read.
- R6: Each entry stores its own framing error. `rd_ferr` is 1 when the stop bit of the head character was sampled low, and 0 when it was sampled high.
- R7: A character waiting in the holding register enters the FIFO in the same clock as the read that frees a slot, so back-to-back reads return it with no gap.
- R8: When the FIFO is full, a character is waiting, and a new start bit is confirmed, the waiting character is dropped. `rd_ovr` becomes 1 for the newest FIFO entry, and all other entries read with `rd_ovr` = 0.
- R9: While `rx_en` is 0, the FIFO and the holding register are empty, `rx_avail` is 0, and no character is received.
- R10: `irq` equals `irq_en` AND `rx_avail`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; low flushes all stored characters |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| rd_stb | input | 1 | Read strobe; pops the head entry |
| irq_en | input | 1 | Interrupt enable |
| rd_data | output | DATA_W | Head character data |
| rd_ferr | output | 1 | Framing error of the head character |
| rd_ovr | output | 1 | Overrun marker of the head character |
| rx_avail | output | 1 | FIFO holds unread data |
| irq | output | 1 | Receive interrupt request |

## Verification
The bench uses the default parameters: 8 data bits, a 16x oversampling rate, a two-entry FIFO and a two-stage input synchroniser. It pulses the tick every second clock, so one bit lasts 32 clocks. With only two slots, a three-character burst fills the FIFO and occupies the holding register. A fourth start bit then produces the overrun case. The bench also reads the FIFO in consecutive cycles to show that the waiting character moves in with no gap.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser #(
  parameter int DATA_W      = 8,
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              os_tick,
  input  logic              rxd,
  output logic              start_det,
  output logic              char_vld,
  output logic [DATA_W-1:0] char_data,
  output logic              char_ferr
);
  import uart_rx_pkg::*;

  localparam int HALF = OS_RATE / 2;
  localparam int CW   = $clog2(OS_RATE);
  localparam int IW   = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;
  rx_state_t              state;
  logic [CW-1:0]          cnt;
  logic [IW-1:0]          idx;
  logic [DATA_W-1:0]      shreg;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
  end
  assign rx_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state     <= RX_IDLE;
      cnt       <= '0;
      idx       <= '0;
      start_det <= 1'b0;
      char_vld  <= 1'b0;
      char_ferr <= 1'b0;
      shreg     <= '0;
    end else begin
      start_det <= 1'b0;
      char_vld  <= 1'b0;
      if (os_tick) begin
        unique case (state)
          RX_IDLE: begin
            if (!rx_s) begin
              state <= RX_START;
              cnt   <= CW'(1);
            end
          end
          RX_START: begin
            if (cnt == CW'(HALF - 1)) begin
              cnt <= '0;
              if (!rx_s) begin
                state     <= RX_DATA;
                idx       <= '0;
                start_det <= 1'b1;
              end else begin
                state <= RX_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt == CW'(OS_RATE - 1)) begin
              cnt   <= '0;
              shreg <= {rx_s, shreg[DATA_W-1:1]};
              if (idx == IW'(DATA_W - 1)) state <= RX_STOP;
              else                        idx   <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt == CW'(OS_RATE - 1)) begin
              cnt       <= '0;
              char_vld  <= 1'b1;
              char_ferr <= ~rx_s;
              state     <= RX_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  assign char_data = shreg;
endmodule

// File: rtl/uart_rx_fifo_store.sv
module uart_rx_fifo_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       push,
  input  logic [DATA_W-1:0]          push_data,
  input  logic                       push_ferr,
  input  logic                       pop,
  input  logic                       mark_ovr,
  output logic [DATA_W-1:0]          head_data,
  output logic                       head_ferr,
  output logic                       head_ovr,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int EW    = DATA_W + 1;

  logic [EW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] ovr_bits;
  logic [PW-1:0]    wr_ptr, rd_ptr, last_ptr;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign last_ptr = (wr_ptr == '0) ? PW'(DEPTH - 1) : wr_ptr - 1'b1;

  // data and framing status: write-only port, no reset, RAM-friendly
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {push_ferr, push_data};
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      ovr_bits <= '0;
    end else begin
      if (push) begin
        wr_ptr           <= ptr_inc(wr_ptr);
        ovr_bits[wr_ptr] <= 1'b0;
      end
      if (mark_ovr) ovr_bits[last_ptr] <= 1'b1;
      if (pop) rd_ptr <= ptr_inc(rd_ptr);
      unique case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_data = mem[rd_ptr][DATA_W-1:0];
  assign head_ferr = mem[rd_ptr][DATA_W] & (count != CNT_W'(0));
  assign head_ovr  = ovr_bits[rd_ptr] & (count != CNT_W'(0));
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer #(
  parameter int DATA_W      = 8,
  parameter int OS_RATE     = 16,
  parameter int DEPTH       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic              rd_stb,
  input  logic              irq_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ferr,
  output logic              rd_ovr,
  output logic              rx_avail,
  output logic              irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              start_det, char_vld, char_ferr;
  logic [DATA_W-1:0] char_data;
  logic [CNT_W-1:0]  count;
  logic              fifo_full, pop, push, hold_move, direct_push, ovr_evt, to_hold;
  logic              hold_valid, hold_ferr;
  logic [DATA_W-1:0] hold_data;
  logic [DATA_W-1:0] push_data;
  logic              push_ferr;

  uart_rx_deser #(
    .DATA_W(DATA_W), .OS_RATE(OS_RATE), .SYNC_STAGES(SYNC_STAGES)
  ) u_deser (
    .clk(clk), .rst(rst), .en(rx_en), .os_tick(os_tick), .rxd(rxd),
    .start_det(start_det), .char_vld(char_vld),
    .char_data(char_data), .char_ferr(char_ferr)
  );

  assign fifo_full   = (count == CNT_W'(DEPTH));
  assign rx_avail    = (count != CNT_W'(0));
  assign pop         = rd_stb & rx_avail & rx_en;
  assign hold_move   = hold_valid & (~fifo_full | pop);
  assign direct_push = char_vld & ~hold_valid & (~fifo_full | pop);
  assign to_hold     = char_vld & ~direct_push;
  assign ovr_evt     = start_det & hold_valid & fifo_full & ~pop;
  assign push        = rx_en & (hold_move | direct_push);
  assign push_data   = hold_valid ? hold_data : char_data;
  assign push_ferr   = hold_valid ? hold_ferr : char_ferr;

  always_ff @(posedge clk) begin
    if (rst || !rx_en) begin
      hold_valid <= 1'b0;
      hold_data  <= '0;
      hold_ferr  <= 1'b0;
    end else if (to_hold) begin
      hold_valid <= 1'b1;
      hold_data  <= char_data;
      hold_ferr  <= char_ferr;
    end else if (hold_move || ovr_evt) begin
      hold_valid <= 1'b0;
    end
  end

  uart_rx_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(~rx_en),
    .push(push), .push_data(push_data), .push_ferr(push_ferr),
    .pop(pop), .mark_ovr(ovr_evt),
    .head_data(rd_data), .head_ferr(rd_ferr), .head_ovr(rd_ovr),
    .count(count)
  );

  assign irq = irq_en & rx_avail;
endmodule

// File: rtl/uart_rx_buffer_chk.sv
module uart_rx_buffer_chk #(
  parameter int DEPTH = 2,
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_en,
  input logic             rd_stb,
  input logic             irq_en,
  input logic             rx_avail,
  input logic             irq,
  input logic [CNT_W-1:0] count,
  input logic             hold_valid,
  input logic             ovr_evt,
  input logic             push
);
  AST_RESET_EMPTY: assert property (@(posedge clk) rst |=> !rx_avail && !irq); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) count <= CNT_W'(DEPTH)); // R3
  AST_LAST_POP: assert property (@(posedge clk) disable iff (rst)
    (rx_en && rd_stb && count == CNT_W'(1) && !push) |=> !rx_avail); // R4
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
    (rx_en && rd_stb && !rx_avail && !push) |=> !rx_avail); // R5
  AST_HOLD_MOVES: assert property (@(posedge clk) disable iff (rst)
    (rx_en && hold_valid && rd_stb && rx_avail) |=> !hold_valid); // R7
  AST_OVR_DROP: assert property (@(posedge clk) disable iff (rst) ovr_evt |=> !hold_valid); // R8
  AST_FLUSH: assert property (@(posedge clk) disable iff (rst) !rx_en |=> !rx_avail && !hold_valid); // R9
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (rst) !irq_en |-> !irq); // R10
endmodule

bind uart_rx_buffer uart_rx_buffer_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .rx_en(rx_en), .rd_stb(rd_stb), .irq_en(irq_en),
  .rx_avail(rx_avail), .irq(irq), .count(count), .hold_valid(hold_valid),
  .ovr_evt(ovr_evt), .push(push)
);

// File: tb/uart_rx_buffer_tb.sv
module uart_rx_buffer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int OS_RATE    = 16;
  localparam int BIT_CLKS   = OS_RATE * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst, rx_en, os_tick, rxd, rd_stb, irq_en;
  logic [7:0] rd_data;
  logic       rd_ferr, rd_ovr, rx_avail, irq;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_buffer u_dut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .os_tick(os_tick), .rxd(rxd),
    .rd_stb(rd_stb), .irq_en(irq_en), .rd_data(rd_data), .rd_ferr(rd_ferr),
    .rd_ovr(rd_ovr), .rx_avail(rx_avail), .irq(irq)
  );

  initial begin
    os_tick = 1'b0;
    forever begin
      for (int i = 0; i < TICK_DIV; i++) begin
        @(negedge clk);
        os_tick = (i == TICK_DIV - 1);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic good_stop);
    rxd = 1'b0; idle(BIT_CLKS);
    for (int b = 0; b < 8; b++) begin rxd = d[b]; idle(BIT_CLKS); end
    if (good_stop) begin
      rxd = 1'b1; idle(BIT_CLKS);
    end else begin
      rxd = 1'b0; idle(20);
      rxd = 1'b1; idle(BIT_CLKS - 20);
    end
  endtask

  task automatic do_read(output logic [7:0] d, output logic fe, output logic ov);
    d = rd_data; fe = rd_ferr; ov = rd_ovr;
    rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1; idle(3); rst = 1'b0; idle(2);
    check("R1 rx_avail after reset", rx_avail, 0);
    check("R1 irq after reset", irq, 0);
  endtask

  task automatic t_single;
    logic [7:0] d; logic fe, ov;
    send_frame(8'hA5, 1'b1); idle(4);
    check("R4 avail after one char", rx_avail, 1);
    do_read(d, fe, ov);
    check("R2 data lsb first", d, 8'hA5);
    check("R6 good stop ferr", fe, 0);
    check("R4 avail after read", rx_avail, 0);
  endtask

  task automatic t_glitch;
    rxd = 1'b0; idle(BIT_CLKS/4); rxd = 1'b1; idle(3*BIT_CLKS);
    check("R2 short pulse ignored", rx_avail, 0);
  endtask

  task automatic t_order;
    logic [7:0] d; logic fe, ov;
    send_frame(8'h3C, 1'b1); send_frame(8'hC1, 1'b1); idle(4);
    check("R3 head before pop", rd_data, 8'h3C);
    do_read(d, fe, ov); check("R3 first out", d, 8'h3C);
    do_read(d, fe, ov); check("R3 second out", d, 8'hC1);
    check("R4 empty after two", rx_avail, 0);
  endtask

  task automatic t_ferr;
    logic [7:0] d; logic fe, ov;
    send_frame(8'h5A, 1'b0); send_frame(8'h0F, 1'b1); idle(4);
    do_read(d, fe, ov);
    check("R6 bad stop data", d, 8'h5A);
    check("R6 bad stop ferr", fe, 1);
    do_read(d, fe, ov);
    check("R6 next char ferr clear", fe, 0);
    check("R6 next char data", d, 8'h0F);
  endtask

  task automatic t_empty_read;
    logic [7:0] d; logic fe, ov;
    rd_stb = 1'b1; idle(3); rd_stb = 1'b0; idle(2);
    check("R5 empty read avail", rx_avail, 0);
    send_frame(8'h77, 1'b1); idle(4);
    check("R5 avail after char", rx_avail, 1);
    do_read(d, fe, ov);
    check("R5 data after empty read", d, 8'h77);
    check("R5 single read empties", rx_avail, 0);
  endtask

  task automatic t_hold_move;
    logic [7:0] d; logic fe, ov;
    send_frame(8'h11, 1'b1); send_frame(8'h22, 1'b1); send_frame(8'h33, 1'b1); idle(4);
    do_read(d, fe, ov); check("R7 read 1", d, 8'h11);
    do_read(d, fe, ov); check("R7 read 2", d, 8'h22);
    do_read(d, fe, ov); check("R7 waiting char no gap", d, 8'h33);
    check("R7 ovr clear without overrun", ov, 0);
    check("R7 empty after three", rx_avail, 0);
  endtask

  task automatic t_overrun;
    logic [7:0] d; logic fe, ov;
    send_frame(8'h41, 1'b1); send_frame(8'h42, 1'b1);
    send_frame(8'h43, 1'b1); send_frame(8'h44, 1'b1); idle(4);
    do_read(d, fe, ov);
    check("R8 oldest data", d, 8'h41); check("R8 oldest ovr", ov, 0);
    do_read(d, fe, ov);
    check("R8 newest data", d, 8'h42); check("R8 newest ovr", ov, 1);
    do_read(d, fe, ov);
    check("R8 waiting char dropped", d, 8'h44); check("R8 later ovr", ov, 0);
    check("R8 empty at end", rx_avail, 0);
  endtask

  task automatic t_flush;
    send_frame(8'h99, 1'b1); send_frame(8'h98, 1'b1); idle(4);
    check("R9 full before flush", rx_avail, 1);
    rx_en = 1'b0; idle(2);
    check("R9 flushed", rx_avail, 0);
    send_frame(8'h55, 1'b1); idle(4);
    check("R9 no receive while disabled", rx_avail, 0);
    rx_en = 1'b1; idle(4);
    check("R9 still empty on enable", rx_avail, 0);
  endtask

  task automatic t_irq;
    logic [7:0] d; logic fe, ov;
    irq_en = 1'b0;
    send_frame(8'h12, 1'b1); idle(4);
    check("R10 irq masked", irq, 0);
    irq_en = 1'b1; idle(1);
    check("R10 irq raised", irq, 1);
    do_read(d, fe, ov);
    check("R10 irq drops when empty", irq, 0);
  endtask

  initial begin
    rst = 1'b1; rx_en = 1'b1; rxd = 1'b1; rd_stb = 1'b0; irq_en = 1'b0;
    t_reset;
    t_single;
    t_glitch;
    t_order;
    t_ferr;
    t_empty_read;
    t_hold_move;
    t_overrun;
    t_flush;
    t_irq;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule